// File: doc/BRIEF.md
# Two-Stage Fixed-Point Multiply-Add Pipeline

This block evaluates `b*c + d` for a stream of independent signed fixed-point operand triples. The first register stage forms the exact product at twice the operand width. The second stage aligns the addend to that product, adds the two, and then applies a single rounding step and saturation to bring the sum back to the operand width. A small opaque tag rides along with every operation, so the consumer can match each result to its request.

Both stream edges use a valid/ready handshake. A triple is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is held high, the pipeline takes one triple per cycle and returns one result per cycle, with a fixed two-cycle latency. When the consumer stalls, a waiting result stays frozen. The pipeline keeps accepting work until both stages are full. No result is lost or duplicated, and results leave in issue order.

The pipeline does not check whether an operand depends on an earlier result. A caller must not feed a result back into the operation issued directly after it.

Top module: `mac2_pipe`

## Requirements
- R1: Operands and the result are two's complement numbers of DATA_W bits with FRAC_W fraction bits (defaults 16 and 8). The result equals the exact value of b*c + d with one rounding applied to it. For example, b = 16.0 and c = 10.0 give a product of 160.0, which is outside the output range, and d = -100.0 still gives exactly 60.0.
- R2: With the default rounding mode, the part of the sum below the output LSB is rounded half up: a remainder of exactly one half rounds toward plus infinity. Examples in output-LSB units: 0.5 becomes 1, -0.5 becomes 0, 1.5 becomes 2, -1.5 becomes -1, and 0.496 becomes 0.
- R3: A rounded value above 2^(DATA_W-1)-1 produces 0x7FFF. A rounded value below -2^(DATA_W-1) produces 0x8000. The hex values are for the default width.
- R4: A triple accepted in cycle k is presented with `out_valid` high in cycle k+2, provided `out_ready` stays high.
- R5: With `out_ready` high, `in_ready` stays high and a new triple can be accepted every cycle. The last result of a burst of n back-to-back triples appears n+1 cycles after the first triple is accepted.
- R6: Each result comes out with the `in_tag` value that was accepted together with its operands.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_tag` hold their values on the next cycle. Every accepted triple produces exactly one result, and results leave in acceptance order.
- R8: `in_ready` is low only when both stages hold an operation and the output is stalled. A triple offered while `in_ready` is low is not taken, and it is accepted later with its own operands.
- R9: A synchronous reset `rst` empties both stages. After reset, `out_valid` is 0 and `in_ready` is 1, and any operation in flight when reset was applied is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand triple offered |
| in_ready | output | 1 | Pipeline can take a triple this cycle |
| in_b | input | DATA_W | Multiplicand, signed fixed-point |
| in_c | input | DATA_W | Multiplier, signed fixed-point |
| in_d | input | DATA_W | Addend, signed fixed-point |
| in_tag | input | TAG_W | Opaque tag carried with the operation |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | DATA_W | Rounded, saturated b*c + d |
| out_tag | output | TAG_W | Tag of the operation being returned |

## Verification
The hardest state to reach from the ports is a full pipeline: both stages occupied, the output stalled, and a third triple waiting at the input. Reaching it requires dropping `out_ready` before the first result arrives and then offering two more triples back to back. The stimulus does exactly that. It then holds the third triple on the input for several cycles and confirms that `in_ready` stays low and the waiting result stays frozen. After release, all three results must come out in order with their own tags. A second hard case is an intermediate product that overflows the output range and is pulled back in by the addend. It is reached by picking operand values whose product alone would saturate.

// File: rtl/mac2_pkg.sv
package mac2_pkg;

  // Selects how the bits below the output LSB are disposed of.
  typedef enum logic {
    RND_HALF_UP = 1'b0,
    RND_TRUNC   = 1'b1
  } rnd_mode_e;

endpackage

// File: rtl/mac2_round_sat.sv
module mac2_round_sat #(
  parameter int                  IN_W   = 34,
  parameter int                  DATA_W = 16,
  parameter int                  FRAC_W = 8,
  parameter mac2_pkg::rnd_mode_e RND    = mac2_pkg::RND_HALF_UP
) (
  input  logic signed [IN_W-1:0]   sum_in,
  output logic        [DATA_W-1:0] res_out
);

  localparam int EXT_W = IN_W + 1;
  localparam logic signed [EXT_W-1:0] MAX_V =
    {{(EXT_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] MIN_V =
    {{(EXT_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [EXT_W-1:0] HALF =
    {{(EXT_W-1){1'b0}}, 1'b1} << (FRAC_W-1);

  logic signed [EXT_W-1:0] sum_x;
  logic signed [EXT_W-1:0] biased;
  logic signed [EXT_W-1:0] shifted;

  assign sum_x = {sum_in[IN_W-1], sum_in};

  // The only rounding point of the datapath: bias then floor-shift.
  generate
    if (RND == mac2_pkg::RND_HALF_UP) begin : g_half_up
      assign biased = sum_x + HALF;
    end else begin : g_trunc
      assign biased = sum_x;
    end
  endgenerate

  assign shifted = biased >>> FRAC_W;

  always_comb begin
    if (shifted > MAX_V)      res_out = MAX_V[DATA_W-1:0];
    else if (shifted < MIN_V) res_out = MIN_V[DATA_W-1:0];
    else                      res_out = shifted[DATA_W-1:0];
  end

endmodule

// File: rtl/mac2_mul_stage.sv
module mac2_mul_stage #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic                      in_valid,
  input  logic signed [DATA_W-1:0]  in_b,
  input  logic signed [DATA_W-1:0]  in_c,
  input  logic signed [DATA_W-1:0]  in_d,
  input  logic        [TAG_W-1:0]   in_tag,
  output logic                      s1_v,
  output logic signed [2*DATA_W-1:0] prod_q,
  output logic signed [DATA_W-1:0]  d_q,
  output logic        [TAG_W-1:0]   tag_q
);

  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod_d;

  // Exact product; no bits are dropped here.
  assign prod_d = in_b * in_c;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else if (load) s1_v <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (load && in_valid) begin
      prod_q <= prod_d;
      d_q    <= in_d;
      tag_q  <= in_tag;
    end
  end

  // R7: an occupied stage that cannot move on keeps its contents.
  p_s1_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (s1_v && !load) |=> (s1_v && $stable(prod_q) && $stable(d_q) && $stable(tag_q)));

endmodule

// File: rtl/mac2_add_stage.sv
module mac2_add_stage #(
  parameter int                  DATA_W = 16,
  parameter int                  FRAC_W = 8,
  parameter int                  TAG_W  = 4,
  parameter mac2_pkg::rnd_mode_e RND    = mac2_pkg::RND_HALF_UP
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic                       s1_v,
  input  logic signed [2*DATA_W-1:0] prod_in,
  input  logic signed [DATA_W-1:0]   d_in,
  input  logic        [TAG_W-1:0]    tag_in,
  output logic                       s2_v,
  output logic        [DATA_W-1:0]   res_q,
  output logic        [TAG_W-1:0]    tag_q
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int SUM_W  = PROD_W + 2;

  logic signed [SUM_W-1:0] prod_x;
  logic signed [SUM_W-1:0] d_x;
  logic signed [SUM_W-1:0] sum;
  logic        [DATA_W-1:0] res_d;

  // Align the addend's binary point with the double-width product.
  assign prod_x = {{(SUM_W-PROD_W){prod_in[PROD_W-1]}}, prod_in};
  assign d_x    = {{(SUM_W-DATA_W){d_in[DATA_W-1]}}, d_in} <<< FRAC_W;
  assign sum    = prod_x + d_x;

  mac2_round_sat #(
    .IN_W   (SUM_W),
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .RND    (RND)
  ) i_round_sat (
    .sum_in  (sum),
    .res_out (res_d)
  );

  always_ff @(posedge clk) begin
    if (rst) s2_v <= 1'b0;
    else if (load) s2_v <= s1_v;
  end

  always_ff @(posedge clk) begin
    if (load && s1_v) begin
      res_q <= res_d;
      tag_q <= tag_in;
    end
  end

  // R6: the tag presented by stage one is the tag stage two returns.
  p_tag_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (load && s1_v) |=> (s2_v && (tag_q == $past(tag_in))));

endmodule

// File: rtl/mac2_pipe.sv
module mac2_pipe #(
  parameter int                  DATA_W = 16,
  parameter int                  FRAC_W = 8,
  parameter int                  TAG_W  = 4,
  parameter mac2_pkg::rnd_mode_e RND    = mac2_pkg::RND_HALF_UP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_c,
  input  logic [DATA_W-1:0] in_d,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [TAG_W-1:0]  out_tag
);

  localparam int PROD_W = 2 * DATA_W;

  logic                     s1_v;
  logic                     s2_v;
  logic                     s1_load;
  logic                     s2_load;
  logic signed [PROD_W-1:0] s1_prod;
  logic signed [DATA_W-1:0] s1_d;
  logic        [TAG_W-1:0]  s1_tag;

  // A stage advances when it is empty or its successor advances.
  assign s2_load  = !s2_v || out_ready;
  assign s1_load  = !s1_v || s2_load;
  assign in_ready = s1_load;

  mac2_mul_stage #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W)
  ) i_mul (
    .clk      (clk),
    .rst      (rst),
    .load     (s1_load),
    .in_valid (in_valid),
    .in_b     ($signed(in_b)),
    .in_c     ($signed(in_c)),
    .in_d     ($signed(in_d)),
    .in_tag   (in_tag),
    .s1_v     (s1_v),
    .prod_q   (s1_prod),
    .d_q      (s1_d),
    .tag_q    (s1_tag)
  );

  mac2_add_stage #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .TAG_W  (TAG_W),
    .RND    (RND)
  ) i_add (
    .clk     (clk),
    .rst     (rst),
    .load    (s2_load),
    .s1_v    (s1_v),
    .prod_in (s1_prod),
    .d_in    (s1_d),
    .tag_in  (s1_tag),
    .s2_v    (s2_v),
    .res_q   (out_result),
    .tag_q   (out_tag)
  );

  assign out_valid = s2_v;

  // R7: a stalled result is frozen.
  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_tag)));

  // R8: input back-pressure only comes from a stalled output.
  p_ready_stall_r8: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid && !out_ready && s1_v));

  // R9: the cycle after reset shows an empty pipeline.
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

endmodule

// File: tb/test_mac2_pipe.sv
module test_mac2_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int F = 8;
  localparam int T = 4;
  localparam int QD = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_b = '0;
  logic [W-1:0] in_c = '0;
  logic [W-1:0] in_d = '0;
  logic [T-1:0] in_tag = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic [T-1:0] out_tag;

  mac2_pipe #(.DATA_W(W), .FRAC_W(F), .TAG_W(T)) i_mac2_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_b(in_b), .in_c(in_c), .in_d(in_d), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_tag(out_tag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit lat_on = 1'b0;
  string cur_req = "R1";

  longint q_res [QD];
  logic [T-1:0] q_tag [QD];
  int q_cyc [QD];
  string q_req [QD];
  int wr = 0;
  int rd = 0;
  int last_out_cyc = 0;

  logic         prev_ov = 1'b0;
  logic         prev_or = 1'b0;
  logic [W-1:0] prev_res = '0;
  logic [T-1:0] prev_tag = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference: exact b*c + d, one half-up rounding, then clamp.
  function automatic longint ref_mac(input longint b, input longint c, input longint d);
    longint s;
    longint r;
    s = b * c + (d * (longint'(1) <<< F));
    r = (s + (longint'(1) <<< (F-1))) >>> F;
    if (r > (longint'(1) <<< (W-1)) - 1) r = (longint'(1) <<< (W-1)) - 1;
    if (r < -(longint'(1) <<< (W-1)))    r = -(longint'(1) <<< (W-1));
    return r;
  endfunction

  // Scoreboard and output monitor, sampled on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      prev_ov = 1'b0;
    end else begin
      if (prev_ov && !prev_or) begin
        check(out_valid && out_result == prev_res && out_tag == prev_tag,
              "R7", "stalled result held", longint'($signed(out_result)),
              longint'($signed(prev_res)));
      end
      if (out_valid && out_ready) begin
        if (rd == wr) begin
          check(1'b0, "R7", "result without request", 1, 0);
        end else begin
          check(longint'($signed(out_result)) == q_res[rd % QD], q_req[rd % QD],
                "result value", longint'($signed(out_result)), q_res[rd % QD]);
          check(out_tag == q_tag[rd % QD], "R6", "tag", longint'(out_tag),
                longint'(q_tag[rd % QD]));
          if (lat_on)
            check(cyc - q_cyc[rd % QD] == 2, "R4", "latency",
                  cyc - q_cyc[rd % QD], 2);
          last_out_cyc = cyc;
          rd++;
        end
      end
      if (in_valid && in_ready) begin
        q_res[wr % QD] = ref_mac(longint'($signed(in_b)), longint'($signed(in_c)),
                                 longint'($signed(in_d)));
        q_tag[wr % QD] = in_tag;
        q_cyc[wr % QD] = cyc;
        q_req[wr % QD] = cur_req;
        wr++;
      end
      prev_ov  = out_valid;
      prev_or  = out_ready;
      prev_res = out_result;
      prev_tag = out_tag;
    end
  end

  // Called just after a rising edge; returns just after the accepting edge.
  task automatic send(input logic [W-1:0] b, input logic [W-1:0] c,
                      input logic [W-1:0] d, input logic [T-1:0] tag,
                      input string req);
    in_b = b; in_c = c; in_d = d; in_tag = tag; cur_req = req;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 30 && rd != wr; i++) @(posedge clk);
    check(rd == wr, "R7", "all results returned", rd, wr);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(!out_valid, "R9", "out_valid in reset", out_valid, 0);
    check(in_ready, "R9", "in_ready in reset", in_ready, 1);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R9", "empty after reset", out_valid, 0);
    @(posedge clk); #1;
    // Reset with an operation in flight discards it.
    send(16'd256, 16'd256, 16'd0, 4'h1, "R9");
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rd = wr;
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!out_valid, "R9", "flushed op stays gone", out_valid, 0);
    end
    @(posedge clk); #1;
  endtask

  task automatic t_basic();
    lat_on = 1'b1;
    send(16'd384, 16'd512, 16'd64, 4'h2, "R1");
    send(16'hFE80, 16'd512, 16'd64, 4'h3, "R1");
    send(16'd100, 16'hFF9C, 16'hF000, 4'h4, "R1");
    send(16'd4096, 16'd2560, 16'h9C00, 4'h5, "R1");
    drain();
    lat_on = 1'b0;
  endtask

  task automatic t_ties();
    lat_on = 1'b1;
    send(16'd1, 16'd128, 16'd0, 4'h6, "R2");
    send(16'hFFFF, 16'd128, 16'd0, 4'h7, "R2");
    send(16'd3, 16'd128, 16'd0, 4'h8, "R2");
    send(16'hFFFD, 16'd128, 16'd0, 4'h9, "R2");
    send(16'd1, 16'd127, 16'd0, 4'hA, "R2");
    send(16'd1, 16'd129, 16'd0, 4'hB, "R2");
    drain();
    lat_on = 1'b0;
  endtask

  task automatic t_saturate();
    send(16'h7FFF, 16'h7FFF, 16'h7FFF, 4'hC, "R3");
    send(16'h7FFF, 16'h8000, 16'h8000, 4'hD, "R3");
    send(16'd256, 16'h7FFF, 16'd0, 4'hE, "R3");
    send(16'd256, 16'h7FFF, 16'd1, 4'hF, "R3");
    send(16'd256, 16'h8000, 16'hFFFF, 4'h0, "R3");
    drain();
  endtask

  task automatic t_burst();
    int start;
    start = wr;
    lat_on = 1'b1;
    for (int i = 0; i < 8; i++) begin
      in_b = W'(i * 300 - 1000); in_c = W'(77 + i * 13);
      in_d = W'(i * 50); in_tag = T'(i); cur_req = "R5";
      in_valid = 1'b1;
      @(negedge clk);
      check(in_ready, "R5", "ready every cycle in burst", in_ready, 1);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    drain();
    check(last_out_cyc - q_cyc[start % QD] == 9, "R5", "burst of 8 span",
          last_out_cyc - q_cyc[start % QD], 9);
    lat_on = 1'b0;
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    send(16'd512, 16'd512, 16'd0, 4'h3, "R7");
    @(negedge clk);
    check(in_ready, "R8", "ready with stage two empty", in_ready, 1);
    @(posedge clk); #1;
    send(16'd256, 16'd768, 16'd256, 4'h9, "R7");
    in_b = 16'hFF00; in_c = 16'd1024; in_d = 16'd0; in_tag = 4'h5;
    cur_req = "R8";
    in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!in_ready, "R8", "ready low when full and stalled", in_ready, 0);
      check(out_valid, "R7", "result waiting while stalled", out_valid, 1);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    drain();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_ties();
    t_saturate();
    t_burst();
    t_backpressure();
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule